// File: doc/BRIEF.md
# Level Register and Trigger Notifier

This block is the front end of an interrupt path for a small set of level-sensitive sources. Each source reports a change of its line with a one-cycle event that carries the source number and the new level. The block keeps those levels in a level register. A separate notify request, tagged with a source number, makes the block issue one 64-bit memory write, called the trigger, to a programmable notification address. The data of that write names the source.

Software reaches four control registers and the read-only level register through a simple 64-bit register port at fixed byte offsets. All of them use MSB-first bit numbering: field bit 0 is the most significant bit (vector index 63) of the word. The control register holds two bits:

- a method bit, which makes the block ignore level events;
- a clear bit, which wipes the level register when it is written as one.

The notification register holds the target address, and its least significant bit marks it valid. The upper half of the vector offset register is added into the trigger data. The trigger leaves through a valid/ready write request followed by a response phase. Only one trigger is outstanding at a time.

Top module: `irq_trigger_notifier`

## Requirements
- R1: After a synchronous reset, every register reads zero, the level vector is zero, no trigger request is shown, busy is low and all flags are low.
- R2: Register reads return data and a read-valid strobe one cycle after the read. Control is at byte offset 0x58, a buffer base at 0x60, notification at 0x68 and vector offset at 0x70, and each reads back the value last written. Offset 0x78 is the level register and is read-only: a write to it changes nothing and raises no flag.
- R3: A read at any other offset returns all ones with bus_err pulsed in the same cycle as the read data. A write at any other offset changes no register and pulses bus_err one cycle later.
- R4: A level event for source i with level 1 sets level bit i, and with level 0 clears it. In the word read at 0x78 that bit sits at vector index 63-i; level_o[i] shows it one cycle after the event.
- R5: While control vector index 63 (method) is set, level events with a valid source number leave the levels unchanged and pulse unsup one cycle later.
- R6: A write to control with vector index 62 set clears all levels, even against a level event in the same cycle. The written value is still stored.
- R7: A level event, or a notify request accepted while idle, whose source number is at or above NUM_SRC pulses src_err one cycle later. It changes no level and emits no trigger.
- R8: A notify request while notification vector index 0 (valid) is clear emits no trigger and leaves busy low.
- R9: An accepted trigger shows the notification register with index 0 cleared as address. Its data is TRIG_FLAG (default vector index 63) ORed with the vector-offset register shifted right by 32 and with the source number. Both values are captured when the request is accepted, and trg_valid rises one cycle after acceptance.
- R10: trg_valid stays high with stable address and data until trg_ready. busy is high from the cycle after acceptance until the cycle after the response. Notify requests while busy are ignored.
- R11: A response with rsp_err set pulses trg_err one cycle later. The trigger is not retried and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Access to an unmapped offset |
| evt_valid | input | 1 | Level event strobe |
| evt_src | input | SRC_W | Source number of the event |
| evt_level | input | 1 | New level of the source |
| ntf_req | input | 1 | Notify request strobe |
| ntf_src | input | SRC_W | Source number for the trigger |
| busy | output | 1 | Trigger outstanding |
| trg_valid | output | 1 | Trigger write request valid |
| trg_ready | input | 1 | Trigger write request accepted |
| trg_addr | output | 64 | Trigger address |
| trg_data | output | 64 | Trigger data, most significant byte at the lowest address |
| rsp_valid | input | 1 | Write response valid |
| rsp_err | input | 1 | Write response is an error |
| level_o | output | NUM_SRC | Current level of each source |
| src_err | output | 1 | Source number out of range |
| unsup | output | 1 | Level event ignored by method bit |
| trg_err | output | 1 | Trigger dropped on error response |

## Verification
The assertions assume that the write target holds rsp_valid only while a trigger awaits its response, and that at most one register access is presented per cycle. The stimulus raises rsp_valid freely, but the block must discard any response outside that phase, so the response checks are qualified by busy with trg_valid low. The stability property assumes the target never withdraws trg_ready within a cycle, and the bench drives ready only from its negedge process. The clear-over-event property assumes a write is the only source of clearing, so the bench never combines a clear with a reset.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  localparam int OFS_CTRL  = 'h58;
  localparam int OFS_BASE  = 'h60;
  localparam int OFS_NTF   = 'h68;
  localparam int OFS_VOFF  = 'h70;
  localparam int OFS_LEVEL = 'h78;

  // MSB-first field numbering: field bit n lives at vector index 63-n
  localparam int CTRL_METHOD_IDX = 63;
  localparam int CTRL_CLEAR_IDX  = 62;
  localparam int NTF_VALID_IDX   = 0;

  typedef enum logic [1:0] {
    TE_IDLE = 2'd0,
    TE_SEND = 2'd1,
    TE_WAIT = 2'd2
  } te_state_t;
endpackage

// File: rtl/irqn_regs.sv
module irqn_regs
  import irqn_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  input  logic [NUM_SRC-1:0] level_vec,
  output logic               method,
  output logic               lvl_clr,
  output logic [63:0]        ntf_q,
  output logic [31:0]        voff_hi,
  output logic [63:0]        reg_rdata,
  output logic               reg_rvalid,
  output logic               bus_err
);
  logic [63:0] ctrl_q, base_q, voff_q, lvl_word;
  logic hit_ctrl, hit_base, hit_ntf, hit_voff, hit_lvl, mapped;

  assign hit_ctrl = reg_addr == ADDR_W'(OFS_CTRL);
  assign hit_base = reg_addr == ADDR_W'(OFS_BASE);
  assign hit_ntf  = reg_addr == ADDR_W'(OFS_NTF);
  assign hit_voff = reg_addr == ADDR_W'(OFS_VOFF);
  assign hit_lvl  = reg_addr == ADDR_W'(OFS_LEVEL);
  assign mapped   = hit_ctrl | hit_base | hit_ntf | hit_voff | hit_lvl;

  // place source i at MSB-first bit i
  always_comb begin
    lvl_word = '0;
    for (int i = 0; i < NUM_SRC; i++) lvl_word[63-i] = level_vec[i];
  end

  assign method  = ctrl_q[CTRL_METHOD_IDX];
  assign lvl_clr = reg_wr & hit_ctrl & reg_wdata[CTRL_CLEAR_IDX];
  assign voff_hi = voff_q[63:32];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      base_q <= '0;
      ntf_q  <= '0;
      voff_q <= '0;
    end else if (reg_wr) begin
      if (hit_ctrl) ctrl_q <= reg_wdata;
      if (hit_base) base_q <= reg_wdata;
      if (hit_ntf)  ntf_q  <= reg_wdata;
      if (hit_voff) voff_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      bus_err    <= (reg_rd | reg_wr) & ~mapped;
      if (reg_rd) begin
        unique case (1'b1)
          hit_ctrl: reg_rdata <= ctrl_q;
          hit_base: reg_rdata <= base_q;
          hit_ntf:  reg_rdata <= ntf_q;
          hit_voff: reg_rdata <= voff_q;
          hit_lvl:  reg_rdata <= lvl_word;
          default:  reg_rdata <= '1;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqn_levels.sv
module irqn_levels #(
  parameter int NUM_SRC = 14,
  parameter int SRC_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid,
  input  logic [SRC_W-1:0]   evt_src,
  input  logic               evt_level,
  input  logic               method,
  input  logic               clr,
  output logic [NUM_SRC-1:0] level_q,
  output logic               evt_bad,
  output logic               unsup
);
  logic evt_ok;

  assign evt_bad = evt_valid & (int'(evt_src) >= NUM_SRC);
  assign evt_ok  = evt_valid & ~evt_bad & ~method;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst || clr)
        level_q[i] <= 1'b0;
      else if (evt_ok && evt_src == SRC_W'(i))
        level_q[i] <= evt_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) unsup <= 1'b0;
    else     unsup <= evt_valid & ~evt_bad & method;
  end
endmodule

// File: rtl/irqn_trigger.sv
module irqn_trigger
  import irqn_pkg::*;
#(
  parameter int          NUM_SRC   = 14,
  parameter int          SRC_W     = 5,
  parameter logic [63:0] TRIG_FLAG = 64'h8000_0000_0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ntf_req,
  input  logic [SRC_W-1:0] ntf_src,
  input  logic [63:0]      ntf_q,
  input  logic [31:0]      voff_hi,
  input  logic             trg_ready,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  output logic             busy,
  output logic             trg_valid,
  output logic [63:0]      trg_addr,
  output logic [63:0]      trg_data,
  output logic             trg_err,
  output logic             req_bad
);
  te_state_t state;
  logic idle, accept;

  assign idle    = state == TE_IDLE;
  assign req_bad = ntf_req & idle & (int'(ntf_src) >= NUM_SRC);
  assign accept  = ntf_req & idle & ~req_bad & ntf_q[NTF_VALID_IDX];

  assign busy      = ~idle;
  assign trg_valid = state == TE_SEND;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TE_IDLE;
      trg_addr <= '0;
      trg_data <= '0;
      trg_err  <= 1'b0;
    end else begin
      trg_err <= 1'b0;
      unique case (state)
        TE_IDLE: if (accept) begin
          trg_addr <= ntf_q & ~(64'd1 << NTF_VALID_IDX);
          trg_data <= TRIG_FLAG | {32'd0, voff_hi} | 64'(ntf_src);
          state    <= TE_SEND;
        end
        TE_SEND: if (trg_ready) state <= TE_WAIT;
        TE_WAIT: if (rsp_valid) begin
          trg_err <= rsp_err;
          state   <= TE_IDLE;
        end
        default: state <= TE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_trigger_notifier.sv
module irq_trigger_notifier #(
  parameter int          ADDR_W    = 8,
  parameter int          NUM_SRC   = 14,
  parameter int          SRC_W     = 5,
  parameter logic [63:0] TRIG_FLAG = 64'h8000_0000_0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               reg_rvalid,
  output logic               bus_err,
  input  logic               evt_valid,
  input  logic [SRC_W-1:0]   evt_src,
  input  logic               evt_level,
  input  logic               ntf_req,
  input  logic [SRC_W-1:0]   ntf_src,
  output logic               busy,
  output logic               trg_valid,
  input  logic               trg_ready,
  output logic [63:0]        trg_addr,
  output logic [63:0]        trg_data,
  input  logic               rsp_valid,
  input  logic               rsp_err,
  output logic [NUM_SRC-1:0] level_o,
  output logic               src_err,
  output logic               unsup,
  output logic               trg_err
);
  logic        method, lvl_clr, evt_bad, req_bad;
  logic [63:0] ntf_q;
  logic [31:0] voff_hi;

  irqn_regs #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .level_vec(level_o),
    .method(method), .lvl_clr(lvl_clr), .ntf_q(ntf_q), .voff_hi(voff_hi),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .bus_err(bus_err)
  );

  irqn_levels #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_lvl (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_src(evt_src),
    .evt_level(evt_level), .method(method), .clr(lvl_clr),
    .level_q(level_o), .evt_bad(evt_bad), .unsup(unsup)
  );

  irqn_trigger #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .TRIG_FLAG(TRIG_FLAG)) u_trg (
    .clk(clk), .rst(rst), .ntf_req(ntf_req), .ntf_src(ntf_src),
    .ntf_q(ntf_q), .voff_hi(voff_hi), .trg_ready(trg_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .busy(busy),
    .trg_valid(trg_valid), .trg_addr(trg_addr), .trg_data(trg_data),
    .trg_err(trg_err), .req_bad(req_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) src_err <= 1'b0;
    else     src_err <= evt_bad | req_bad;
  end
endmodule

// File: rtl/irqn_chk.sv
module irqn_chk #(
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 14,
  parameter int SRC_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [63:0]        reg_wdata,
  input logic [63:0]        reg_rdata,
  input logic               reg_rvalid,
  input logic               bus_err,
  input logic               evt_valid,
  input logic [SRC_W-1:0]   evt_src,
  input logic               busy,
  input logic               trg_valid,
  input logic               trg_ready,
  input logic [63:0]        trg_addr,
  input logic [63:0]        trg_data,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [NUM_SRC-1:0] level_o,
  input logic               unsup,
  input logic               trg_err
);
  logic odd_addr;
  assign odd_addr = reg_addr != ADDR_W'('h58) && reg_addr != ADDR_W'('h60) &&
                    reg_addr != ADDR_W'('h68) && reg_addr != ADDR_W'('h70) &&
                    reg_addr != ADDR_W'('h78);

  // R10
  trg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trg_valid && !trg_ready |=> trg_valid && $stable(trg_addr) && $stable(trg_data));

  // R10
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    trg_valid |-> busy);

  // R9
  addr_clean_chk: assert property (@(posedge clk) disable iff (rst)
    trg_valid |-> !trg_addr[0]);

  // R3
  rd_ones_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd && odd_addr |=> reg_rvalid && bus_err && reg_rdata == '1);

  // R6
  lvl_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == ADDR_W'('h58) && reg_wdata[62] |=> level_o == '0);

  // R5
  method_hold_chk: assert property (@(posedge clk) disable iff (rst)
    unsup && !$past(reg_wr) |-> level_o == $past(level_o));

  // R7
  bad_src_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid && int'(evt_src) >= NUM_SRC && !reg_wr |=> $stable(level_o));

  // R11
  err_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err && busy && !trg_valid |=> trg_err && !busy);
endmodule

bind irq_trigger_notifier irqn_chk #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
  .bus_err(bus_err), .evt_valid(evt_valid), .evt_src(evt_src), .busy(busy),
  .trg_valid(trg_valid), .trg_ready(trg_ready), .trg_addr(trg_addr),
  .trg_data(trg_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .level_o(level_o), .unsup(unsup), .trg_err(trg_err)
);

// File: tb/sim_irq_trigger_notifier.sv
`timescale 1ns/100ps
module sim_irq_trigger_notifier;
  localparam int          ADDR_W = 8;
  localparam int          NSRC   = 14;
  localparam int          SW     = 5;
  localparam logic [63:0] FLAG   = 64'h8000_0000_0000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, evt_valid = 0, evt_level = 0, ntf_req = 0;
  logic trg_ready = 0, rsp_valid = 0, rsp_err = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [SW-1:0] evt_src = '0, ntf_src = '0;
  logic [63:0] reg_rdata, trg_addr, trg_data;
  logic reg_rvalid, bus_err, busy, trg_valid, src_err, unsup, trg_err;
  logic [NSRC-1:0] level_o;

  int vectors = 0, miscmp = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_trigger_notifier #(.ADDR_W(ADDR_W), .NUM_SRC(NSRC), .SRC_W(SW), .TRIG_FLAG(FLAG)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .bus_err(bus_err), .evt_valid(evt_valid), .evt_src(evt_src),
    .evt_level(evt_level), .ntf_req(ntf_req), .ntf_src(ntf_src), .busy(busy),
    .trg_valid(trg_valid), .trg_ready(trg_ready), .trg_addr(trg_addr),
    .trg_data(trg_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .level_o(level_o), .src_err(src_err), .unsup(unsup), .trg_err(trg_err)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_ctrl, m_base, m_ntf, m_voff, m_rdata, m_addr, m_data;
  logic [NSRC-1:0] m_lvl;
  logic m_rvalid, m_buserr, m_srcerr, m_unsup, m_trgerr;
  int m_state; // 0 idle, 1 request shown, 2 waiting for response

  function automatic logic [63:0] lvl_word(input logic [NSRC-1:0] l);
    logic [63:0] w = '0;
    for (int i = 0; i < NSRC; i++) w[63-i] = l[i];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_base = 0; m_ntf = 0; m_voff = 0; m_rdata = 0;
      m_addr = 0; m_data = 0; m_lvl = 0; m_rvalid = 0; m_buserr = 0;
      m_srcerr = 0; m_unsup = 0; m_trgerr = 0; m_state = 0;
    end else begin
      bit known, ebad, nbad;
      known = reg_addr inside {8'h58, 8'h60, 8'h68, 8'h70, 8'h78};
      m_rvalid = reg_rd;
      m_buserr = (reg_rd || reg_wr) && !known;
      if (reg_rd) begin
        case (reg_addr)
          8'h58: m_rdata = m_ctrl;
          8'h60: m_rdata = m_base;
          8'h68: m_rdata = m_ntf;
          8'h70: m_rdata = m_voff;
          8'h78: m_rdata = lvl_word(m_lvl);
          default: m_rdata = '1;
        endcase
      end
      ebad = evt_valid && int'(evt_src) >= NSRC;
      nbad = ntf_req && m_state == 0 && int'(ntf_src) >= NSRC;
      m_unsup  = evt_valid && !ebad && m_ctrl[63];
      m_srcerr = ebad || nbad;
      if (reg_wr && reg_addr == 8'h58 && reg_wdata[62]) m_lvl = '0;
      else if (evt_valid && !ebad && !m_ctrl[63]) m_lvl[evt_src] = evt_level;
      m_trgerr = 0;
      case (m_state)
        0: if (ntf_req && !nbad && m_ntf[0]) begin
             m_addr = {m_ntf[63:1], 1'b0};
             m_data = FLAG | (m_voff >> 32) | 64'(ntf_src);
             m_state = 1;
           end
        1: if (trg_ready) m_state = 2;
        default: if (rsp_valid) begin m_trgerr = rsp_err; m_state = 0; end
      endcase
      if (reg_wr) case (reg_addr)
        8'h58: m_ctrl = reg_wdata;
        8'h60: m_base = reg_wdata;
        8'h68: m_ntf  = reg_wdata;
        8'h70: m_voff = reg_wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R4 level_o", 64'(level_o), 64'(m_lvl));
    chk("R2 rvalid", 64'(reg_rvalid), 64'(m_rvalid));
    chk("R2 rdata", reg_rdata, m_rdata);
    chk("R3 bus_err", 64'(bus_err), 64'(m_buserr));
    chk("R5 unsup", 64'(unsup), 64'(m_unsup));
    chk("R7 src_err", 64'(src_err), 64'(m_srcerr));
    chk("R10 busy", 64'(busy), 64'(m_state != 0));
    chk("R10 trg_valid", 64'(trg_valid), 64'(m_state == 1));
    if (m_state == 1) begin
      chk("R9 trg_addr", trg_addr, m_addr);
      chk("R9 trg_data", trg_data, m_data);
    end
    chk("R11 trg_err", 64'(trg_err), 64'(m_trgerr));
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); @(negedge clk); #0.5;
    reg_wr = 0; reg_rd = 0; evt_valid = 0; ntf_req = 0; rsp_valid = 0; rsp_err = 0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
  endtask
  task automatic rd(input logic [7:0] a);
    reg_rd = 1; reg_addr = a; tick();
  endtask
  task automatic evt(input int s, input logic l);
    evt_valid = 1; evt_src = SW'(s); evt_level = l; tick();
  endtask
  task automatic req(input int s);
    ntf_req = 1; ntf_src = SW'(s); tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      miscmp++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5 rst = 0;
    // R1 reset state
    chk("R1 level", 64'(level_o), 0);
    chk("R1 busy", 64'(busy), 0);
    chk("R1 trg_valid", 64'(trg_valid), 0);
    rd(8'h58); chk("R1 ctrl zero", reg_rdata, 0);
    // R2 register map
    wr(8'h60, 64'h1122_3344_5566_7788); rd(8'h60);
    chk("R2 base", reg_rdata, 64'h1122_3344_5566_7788);
    wr(8'h70, 64'h0000_0120_FFFF_FFFF); rd(8'h70);
    wr(8'h78, '1); rd(8'h78); chk("R2 level ro", reg_rdata, 0);
    // R3 unmapped
    rd(8'h50); chk("R3 ones", reg_rdata, '1);
    wr(8'h40, 64'h5);
    // R4 levels
    evt(0, 1); evt(5, 1); evt(13, 1); evt(5, 0);
    rd(8'h78); chk("R4 word", reg_rdata, 64'h8000_0000_0000_0000 | 64'h0004_0000_0000_0000);
    // R7 bad source
    evt(20, 1); chk("R7 no change", 64'(level_o), 64'h2001);
    // R5 method bit
    wr(8'h58, 64'h8000_0000_0000_0000); evt(3, 1);
    chk("R5 ignored", 64'(level_o[3]), 0);
    wr(8'h58, 0);
    // R6 clear beats concurrent event
    evt(2, 1);
    reg_wr = 1; reg_addr = 8'h58; reg_wdata = 64'h4000_0000_0000_0000;
    evt_valid = 1; evt_src = 7; evt_level = 1; tick();
    chk("R6 cleared", 64'(level_o), 0);
    rd(8'h58); chk("R6 stored", reg_rdata, 64'h4000_0000_0000_0000);
    // R8 notify invalid
    wr(8'h68, 64'h0000_00AB_CDEF_0000); req(3);
    chk("R8 no trigger", 64'(trg_valid), 0);
    chk("R8 not busy", 64'(busy), 0);
    // R9/R10 valid trigger with back-pressure
    wr(8'h68, 64'h0000_00AB_CDEF_0101); req(7);
    chk("R9 addr", trg_addr, 64'h0000_00AB_CDEF_0100);
    chk("R9 data", trg_data, FLAG | 64'h120 | 64'd7);
    wr(8'h70, 0); req(9); tick();
    chk("R10 held", trg_data, FLAG | 64'h120 | 64'd7);
    trg_ready = 1; tick(); trg_ready = 0;
    rsp_valid = 1; tick();
    chk("R10 idle", 64'(busy), 0);
    // R11 error response
    req(1); trg_ready = 1; tick(); trg_ready = 0;
    rsp_valid = 1; rsp_err = 1; tick();
    chk("R11 flag", 64'(trg_err), 1);
    chk("R11 no retry", 64'(trg_valid), 0);
    req(15);
    // mixed traffic
    for (int n = 0; n < 2000; n++) begin
      int k = $urandom_range(0, 9);
      trg_ready = 1'($urandom);
      if (k < 3) begin
        reg_wr = 1; reg_addr = 8'(8'h58 + 8 * $urandom_range(0, 4));
        reg_wdata = {$urandom, $urandom};
        if (reg_addr == 8'h58) reg_wdata[63] = ($urandom_range(0, 3) == 0);
      end else if (k < 5) begin
        reg_rd = 1; reg_addr = 8'(8'h50 + 8 * $urandom_range(0, 6));
      end
      evt_valid = 1'($urandom); evt_src = SW'($urandom_range(0, 16)); evt_level = 1'($urandom);
      ntf_req = 1'($urandom); ntf_src = SW'($urandom_range(0, 16));
      rsp_valid = 1'($urandom); rsp_err = 1'($urandom);
      tick();
    end
    trg_ready = 0;
    repeat (2) tick();
    finish_run();
  end
endmodule